// File: doc/BRIEF.md
# Stack-Partitioned Cache Lookup and Replacement Controller

This controller manages tag lookup and block replacement for an eight-way set-associative first-level data cache. Each access arrives with a class bit that says whether it was predicted to touch the program stack. The bit works as a way predictor. A stack access enables only the lowest ways of the set, up to a configured count, so it costs less array energy. A non-stack access enables every way at once. The bit also forms a soft partition in replacement. A stack fill may only land in the designated ways. A non-stack fill may displace any block of the set.

On a stack miss the controller also looks at the tags outside the designated ways. If the block is sitting in one of those ways, for example because the stack pointer moved, the controller invalidates it. It writes the block back if it is dirty and then fetches it again into an allowed way. The next level is modelled as two request/acknowledge ports: one for writebacks and one for refills. The controller stalls new accesses while a miss is outstanding.

Each accepted access returns a registered response one cycle later. The response carries hit or miss, the hit way or the victim way, and a flag for a misplaced stack block. In the cycle of the request the controller also drives the per-way array enables and a count of how many ways it switched on.

Top module: `stackway_lookup_ctrl`

## Requirements
- R1: With `cfg_stack_ways` of 8 or more, a stack access behaves like a non-stack access: all eight enables are on and the victim search covers the whole set.
- R2: A stack access enables exactly ways 0 to N-1. N is `cfg_stack_ways`, with 0 read as 1 and values above 8 read as 8. The enables (bit w for way w) are high in the cycle the request is accepted.
- R3: A non-stack access enables all eight ways in the cycle it is accepted.
- R4: On a non-stack miss the victim is the lowest-numbered invalid way of the set. If there is none, the victim is the least recently used way of the whole set, stack ways included.
- R5: On a stack miss the victim is the lowest-numbered invalid way among ways 0 to N-1. If there is none, the victim is the least recently used of those N ways.
- R6: Every hit, of either class, makes the hit way most recently used. So does every refill, for the refilled way. After reset the order runs from way 0 (most recent) to way 7 (least recent) in every set.
- R7: On a stack miss where the tag matches a valid block in a way at or above N, the response sets `resp_misplaced`. That block is invalidated and written back if it is dirty, using the request tag. The block is then refilled into an allowed victim way.
- R8: A writeback for a misplaced block comes before a writeback for a dirty victim, and both come before the refill request. Only one request is raised at a time, and each is held until it is acknowledged.
- R9: `req_ready` is low from the accepted miss until the edge that takes `fill_ack`. While it is low, no way enable is raised.
- R10: `en_count` equals the number of way enables raised in the same cycle.
- R11: `resp_valid` pulses in the cycle after each accepted request, together with the hit flag and a way. The way is the hit way on a hit and the chosen victim on a miss.
- R12: A write hit marks the block dirty. A write miss installs the refilled block dirty, and a read miss installs it clean. Only dirty blocks produce a writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_stack_ways | input | 4 | Number of designated stack ways (clamped to 1..8) |
| req_valid | input | 1 | Access request |
| req_stack | input | 1 | Access predicted to target the stack |
| req_write | input | 1 | Access is a store |
| req_index | input | 4 | Set index |
| req_tag | input | 20 | Address tag |
| req_ready | output | 1 | Controller can accept an access |
| way_en | output | 8 | Per-way tag/data array enables |
| en_count | output | 4 | Number of enabled ways this cycle |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 3 | Hit way or victim way |
| resp_misplaced | output | 1 | Stack block found outside the designated ways |
| wb_valid | output | 1 | Writeback request |
| wb_index | output | 4 | Writeback set |
| wb_tag | output | 20 | Writeback tag |
| wb_way | output | 3 | Writeback way |
| wb_ack | input | 1 | Writeback accepted |
| fill_valid | output | 1 | Refill request |
| fill_index | output | 4 | Refill set |
| fill_tag | output | 20 | Refill tag |
| fill_way | output | 3 | Way receiving the refill |
| fill_ack | input | 1 | Refill data delivered |

## Verification
The bench builds the controller with its defaults: 8 ways, 16 sets and a 20-bit tag. It then varies the designated-way count at run time across 0, 1, 2, 3, 5, 8 and 9, so both clamping ends and non-power-of-two partitions are covered. Random traffic is confined to four sets and twelve tags. This keeps sets full, so LRU victims in both partitions, dirty evictions followed by refills, and blocks stranded outside the stack ways when the count shrinks all occur often.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WB_MIS = 2'd1,
    ST_WB_VIC = 2'd2,
    ST_FILL   = 2'd3
  } slc_state_e;

  // Clamp a configured stack way count into 1..ways.
  function automatic int unsigned clamp_ways(int unsigned n, int unsigned ways);
    if (n == 0) return 1;
    if (n > ways) return ways;
    return n;
  endfunction
endpackage

// File: rtl/slc_tag_store.sv
module slc_tag_store #(
  parameter int WAYS  = 8,
  parameter int SETS  = 16,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            idx,
  input  logic [TAG_W-1:0]            lk_tag,
  output logic [WAYS-1:0]             match_vec,
  output logic [WAYS-1:0]             valid_vec,
  output logic [WAYS-1:0]             dirty_vec,
  output logic [WAYS-1:0][TAG_W-1:0]  tag_vec,
  input  logic                        dirty_set_en,
  input  logic [WAY_W-1:0]            dirty_set_way,
  input  logic                        inval_en,
  input  logic [WAY_W-1:0]            inval_way,
  input  logic                        fill_en,
  input  logic [WAY_W-1:0]            fill_way,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic                        fill_dirty
);
  logic [WAYS-1:0]            vld [SETS];
  logic [WAYS-1:0]            drt [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tgs [SETS];

  always_comb begin
    valid_vec = vld[idx];
    dirty_vec = drt[idx];
    tag_vec   = tgs[idx];
    for (int w = 0; w < WAYS; w++)
      match_vec[w] = vld[idx][w] && (tgs[idx][w] == lk_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        drt[s] <= '0;
        tgs[s] <= '0;
      end
    end else begin
      if (dirty_set_en) drt[idx][dirty_set_way] <= 1'b1;
      if (inval_en) begin
        vld[idx][inval_way] <= 1'b0;
        drt[idx][inval_way] <= 1'b0;
      end
      if (fill_en) begin
        vld[idx][fill_way] <= 1'b1;
        drt[idx][fill_way] <= fill_dirty;
        tgs[idx][fill_way] <= fill_tag;
      end
    end
  end
endmodule

// File: rtl/slc_recency.sv
module slc_recency #(
  parameter int WAYS = 8,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [WAYS-1:0]  allow_mask,
  input  logic [WAYS-1:0]  valid_vec,
  output logic [WAY_W-1:0] victim_way
);
  // Age 0 is most recent; ages in a set always form a permutation.
  logic [WAYS-1:0][WAY_W-1:0] ages [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ages[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          ages[idx][w] <= '0;
        else if (ages[idx][w] < ages[idx][touch_way])
          ages[idx][w] <= ages[idx][w] + 1'b1;
      end
    end
  end

  logic             got_free, got_old;
  logic [WAY_W-1:0] free_way, old_way, old_age;

  always_comb begin
    got_free = 1'b0; free_way = '0;
    got_old  = 1'b0; old_way  = '0; old_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (allow_mask[w] && !valid_vec[w] && !got_free) begin
        got_free = 1'b1;
        free_way = WAY_W'(w);
      end
      if (allow_mask[w] && (!got_old || ages[idx][w] > old_age)) begin
        got_old = 1'b1;
        old_way = WAY_W'(w);
        old_age = ages[idx][w];
      end
    end
    victim_way = got_free ? free_way : old_way;
  end

  // R4 / R5: the chosen victim always lies inside the allowed partition.
  a_r5_victim_in_partition: assert property (@(posedge clk) disable iff (!rst_n)
    (|allow_mask) |-> allow_mask[victim_way]);

  // R6: a touched way is most recent on the next cycle.
  a_r6_touch_makes_mru: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (ages[$past(idx)][$past(touch_way)] == '0));
endmodule

// File: rtl/slc_miss_fsm.sv
module slc_miss_fsm
  import slc_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int SETS  = 16,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_start,
  input  logic [IDX_W-1:0] req_index,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_write,
  input  logic             mis_wb_need,
  input  logic [WAY_W-1:0] mis_way,
  input  logic             vic_wb_need,
  input  logic [WAY_W-1:0] vic_way,
  input  logic [TAG_W-1:0] vic_tag,
  input  logic             wb_ack,
  input  logic             fill_ack,
  output slc_state_e       st,
  output logic [IDX_W-1:0] cur_index,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag,
  output logic [WAY_W-1:0] wb_way,
  output logic             fill_valid,
  output logic [TAG_W-1:0] fill_tag,
  output logic [WAY_W-1:0] fill_way,
  output logic             fill_done,
  output logic             fill_dirty
);
  logic [TAG_W-1:0] cur_tag, v_tag;
  logic [WAY_W-1:0] m_way, v_way;
  logic             cur_write, v_wb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cur_index <= '0; cur_tag <= '0; cur_write <= 1'b0;
      m_way <= '0; v_way <= '0; v_tag <= '0; v_wb <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (miss_start) begin
          cur_index <= req_index;
          cur_tag   <= req_tag;
          cur_write <= req_write;
          m_way     <= mis_way;
          v_way     <= vic_way;
          v_tag     <= vic_tag;
          v_wb      <= vic_wb_need;
          st <= mis_wb_need ? ST_WB_MIS : (vic_wb_need ? ST_WB_VIC : ST_FILL);
        end
        ST_WB_MIS: if (wb_ack) st <= v_wb ? ST_WB_VIC : ST_FILL;
        ST_WB_VIC: if (wb_ack) st <= ST_FILL;
        ST_FILL:   if (fill_ack) st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wb_valid   = (st == ST_WB_MIS) || (st == ST_WB_VIC);
    wb_way     = (st == ST_WB_MIS) ? m_way : v_way;
    wb_tag     = (st == ST_WB_MIS) ? cur_tag : v_tag;
    fill_valid = (st == ST_FILL);
    fill_tag   = cur_tag;
    fill_way   = v_way;
    fill_done  = fill_valid && fill_ack;
    fill_dirty = cur_write;
  end

  // R8: never a writeback and a refill at once.
  a_r8_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && fill_valid));

  // R8: an unacknowledged writeback holds its request.
  a_r8_wb_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_tag) && $stable(wb_way)));
endmodule

// File: rtl/stackway_lookup_ctrl.sv
module stackway_lookup_ctrl
  import slc_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int SETS  = 16,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS),
  localparam int CNT_W = $clog2(WAYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_stack_ways,
  input  logic             req_valid,
  input  logic             req_stack,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_index,
  input  logic [TAG_W-1:0] req_tag,
  output logic             req_ready,
  output logic [WAYS-1:0]  way_en,
  output logic [CNT_W-1:0] en_count,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [WAY_W-1:0] resp_way,
  output logic             resp_misplaced,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_index,
  output logic [TAG_W-1:0] wb_tag,
  output logic [WAY_W-1:0] wb_way,
  input  logic             wb_ack,
  output logic             fill_valid,
  output logic [IDX_W-1:0] fill_index,
  output logic [TAG_W-1:0] fill_tag,
  output logic [WAY_W-1:0] fill_way,
  input  logic             fill_ack
);
  slc_state_e st;
  logic [IDX_W-1:0] cur_index, idx;
  logic [CNT_W-1:0] eff_n;
  logic [WAYS-1:0]  stack_mask, allow_mask, class_mask;
  logic [WAYS-1:0]  match_vec, valid_vec, dirty_vec, hit_vec, stray_vec;
  logic [WAYS-1:0][TAG_W-1:0] tag_vec;
  logic             accept, hit, misplaced, miss_start, fill_done, fill_dirty;
  logic [WAY_W-1:0] hit_way, mis_way, victim_way;

  // Designated-way mask: ways 0..eff_n-1.
  always_comb begin
    eff_n = CNT_W'(clamp_ways(int'(cfg_stack_ways), WAYS));
    for (int w = 0; w < WAYS; w++)
      stack_mask[w] = (CNT_W'(w) < eff_n);
  end

  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign class_mask = req_stack ? stack_mask : '1;
  assign allow_mask = class_mask;
  assign idx        = req_ready ? req_index : cur_index;

  // Array enables and the energy proxy count.
  always_comb begin
    way_en   = accept ? class_mask : '0;
    en_count = '0;
    for (int w = 0; w < WAYS; w++)
      en_count = en_count + CNT_W'(way_en[w]);
  end

  slc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(idx), .lk_tag(req_tag),
    .match_vec(match_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
    .tag_vec(tag_vec),
    .dirty_set_en(accept && hit && req_write), .dirty_set_way(hit_way),
    .inval_en(accept && misplaced), .inval_way(mis_way),
    .fill_en(fill_done), .fill_way(fill_way), .fill_tag(fill_tag),
    .fill_dirty(fill_dirty)
  );

  // Hit among enabled ways; on a stack miss the other tags are inspected.
  always_comb begin
    hit_vec   = match_vec & class_mask;
    stray_vec = req_stack ? (match_vec & ~stack_mask) : '0;
    hit       = |hit_vec;
    misplaced = !hit && (|stray_vec);
    hit_way = '0;
    mis_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])   hit_way = WAY_W'(w);
      if (stray_vec[w]) mis_way = WAY_W'(w);
    end
  end

  assign miss_start = accept && !hit;

  slc_recency #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n), .idx(idx),
    .touch_en((accept && hit) || fill_done),
    .touch_way(fill_done ? fill_way : hit_way),
    .allow_mask(allow_mask), .valid_vec(valid_vec), .victim_way(victim_way)
  );

  slc_miss_fsm #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .miss_start(miss_start),
    .req_index(req_index), .req_tag(req_tag), .req_write(req_write),
    .mis_wb_need(misplaced && dirty_vec[mis_way]), .mis_way(mis_way),
    .vic_wb_need(valid_vec[victim_way] && dirty_vec[victim_way]),
    .vic_way(victim_way), .vic_tag(tag_vec[victim_way]),
    .wb_ack(wb_ack), .fill_ack(fill_ack), .st(st), .cur_index(cur_index),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_way(wb_way),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_way(fill_way),
    .fill_done(fill_done), .fill_dirty(fill_dirty)
  );

  assign wb_index   = cur_index;
  assign fill_index = cur_index;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0; resp_hit <= 1'b0;
      resp_way <= '0;     resp_misplaced <= 1'b0;
    end else begin
      resp_valid     <= accept;
      resp_hit       <= accept && hit;
      resp_way       <= hit ? hit_way : victim_way;
      resp_misplaced <= accept && misplaced;
    end
  end

  // R2: a stack access touches no way outside the partition.
  a_r2_stack_ways_only: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_stack) |-> ((way_en & ~stack_mask) == '0) && way_en[0]);

  // R3: a non-stack access powers every way.
  a_r3_nonstack_all_ways: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_stack) |-> (&way_en));

  // R7: a misplaced report is always followed by a miss in progress.
  a_r7_misplaced_is_miss: assert property (@(posedge clk) disable iff (!rst_n)
    resp_misplaced |-> (!req_ready && !resp_hit));

  // R9: while stalled no array is enabled.
  a_r9_stall_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (way_en == '0));

  // R10: the count stays in range for an accepted access.
  a_r10_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (en_count != '0) && (en_count <= CNT_W'(WAYS)));

  // R11: a response follows each acceptance.
  a_r11_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> resp_valid);
endmodule

// File: tb/test_stackway_lookup_ctrl.sv
module test_stackway_lookup_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 8, SETS = 16, TAG_W = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cfg_stack_ways = 4'd2;
  logic req_valid = 0, req_stack = 0, req_write = 0;
  logic [3:0] req_index = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic req_ready, resp_valid, resp_hit, resp_misplaced;
  logic [7:0] way_en;
  logic [3:0] en_count;
  logic [2:0] resp_way, wb_way, fill_way;
  logic wb_valid, fill_valid;
  logic wb_ack = 0, fill_ack = 0;
  logic [3:0] wb_index, fill_index;
  logic [TAG_W-1:0] wb_tag, fill_tag;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stackway_lookup_ctrl i_stackway_lookup_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_stack_ways(cfg_stack_ways),
    .req_valid(req_valid), .req_stack(req_stack), .req_write(req_write),
    .req_index(req_index), .req_tag(req_tag), .req_ready(req_ready),
    .way_en(way_en), .en_count(en_count), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_way(resp_way), .resp_misplaced(resp_misplaced),
    .wb_valid(wb_valid), .wb_index(wb_index), .wb_tag(wb_tag), .wb_way(wb_way),
    .wb_ack(wb_ack), .fill_valid(fill_valid), .fill_index(fill_index),
    .fill_tag(fill_tag), .fill_way(fill_way), .fill_ack(fill_ack)
  );

  // Reference model: validity, dirtiness, tags, recency list (MRU first).
  bit m_valid [SETS][WAYS];
  bit m_dirty [SETS][WAYS];
  int m_tag   [SETS][WAYS];
  int m_order [SETS][WAYS];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(int n);
    if (n < 1) return 1;
    if (n > WAYS) return WAYS;
    return n;
  endfunction

  function automatic int part_mask(bit stk, int n);
    int m = 0;
    for (int w = 0; w < WAYS; w++) if (!stk || w < eff(n)) m |= (1 << w);
    return m;
  endfunction

  function automatic void touch(int s, int w);
    int p = 0;
    for (int k = 0; k < WAYS; k++) if (m_order[s][k] == w) p = k;
    for (int k = p; k > 0; k--) m_order[s][k] = m_order[s][k-1];
    m_order[s][0] = w;
  endfunction

  function automatic int pick_victim(int s, int lim);
    for (int w = 0; w < lim; w++) if (!m_valid[s][w]) return w;
    for (int p = WAYS - 1; p >= 0; p--) if (m_order[s][p] < lim) return m_order[s][p];
    return 0;
  endfunction

  task automatic access(bit stk, bit wr, int s, int tg, int n);
    int lim, hw, mw, vw, nwb, seen_wb, guard;
    int ewb_tag [2];
    int ewb_way [2];
    bit seen_fill;
    lim = stk ? eff(n) : WAYS;
    hw = -1; mw = -1;
    for (int w = 0; w < WAYS; w++)
      if (m_valid[s][w] && m_tag[s][w] == tg) begin
        if (w < lim && hw < 0) hw = w;
        else if (w >= lim && mw < 0) mw = w;
      end
    @(negedge clk);
    cfg_stack_ways = 4'(n); req_stack = stk; req_write = wr;
    req_index = 4'(s); req_tag = TAG_W'(tg); req_valid = 1;
    #1;
    check(int'(way_en) == part_mask(stk, n), stk ? (n >= 8 ? "R1" : "R2") : "R3",
          int'(way_en), part_mask(stk, n));
    check(int'(en_count) == $countones(part_mask(stk, n)), "R10",
          int'(en_count), $countones(part_mask(stk, n)));
    @(negedge clk);
    req_valid = 0;
    check(resp_valid == 1'b1, "R11", int'(resp_valid), 1);
    check(resp_hit == (hw >= 0), "R11", int'(resp_hit), int'(hw >= 0));
    if (hw >= 0) begin
      check(int'(resp_way) == hw, "R6", int'(resp_way), hw);
      check(resp_misplaced == 1'b0, "R7", int'(resp_misplaced), 0);
      touch(s, hw);
      if (wr) m_dirty[s][hw] = 1;
      return;
    end
    nwb = 0;
    if (mw >= 0) begin
      if (m_dirty[s][mw]) begin ewb_tag[nwb] = tg; ewb_way[nwb] = mw; nwb++; end
      m_valid[s][mw] = 0; m_dirty[s][mw] = 0;
    end
    check(resp_misplaced == (mw >= 0), "R7", int'(resp_misplaced), int'(mw >= 0));
    vw = pick_victim(s, lim);
    check(int'(resp_way) == vw, stk ? "R5" : "R4", int'(resp_way), vw);
    if (m_valid[s][vw] && m_dirty[s][vw]) begin
      ewb_tag[nwb] = m_tag[s][vw]; ewb_way[nwb] = vw; nwb++;
    end
    check(req_ready == 1'b0, "R9", int'(req_ready), 0);
    req_valid = 1; #1;
    check(way_en == 8'h00, "R9", int'(way_en), 0);
    req_valid = 0;
    seen_wb = 0; seen_fill = 0; guard = 0;
    while (!req_ready && guard < 40) begin
      if (wb_valid) begin
        if (seen_wb < nwb) begin
          check(int'(wb_tag) == ewb_tag[seen_wb], "R8", int'(wb_tag), ewb_tag[seen_wb]);
          check(int'(wb_way) == ewb_way[seen_wb], "R12", int'(wb_way), ewb_way[seen_wb]);
          check(int'(wb_index) == s, "R8", int'(wb_index), s);
        end
        seen_wb++;
        wb_ack = ($urandom_range(0, 2) != 0);
      end else if (fill_valid) begin
        check(seen_wb == nwb, "R8", seen_wb, nwb);
        check(int'(fill_way) == vw, stk ? "R5" : "R4", int'(fill_way), vw);
        check(int'(fill_tag) == tg, "R8", int'(fill_tag), tg);
        seen_fill = 1;
        fill_ack = 1;
      end
      @(negedge clk);
      if (wb_ack) seen_wb = seen_wb; else if (wb_valid && seen_wb > 0 && seen_wb <= nwb) seen_wb--;
      wb_ack = 0; fill_ack = 0;
      guard++;
    end
    check(seen_fill && req_ready, "R9", int'(seen_fill), 1);
    m_valid[s][vw] = 1; m_dirty[s][vw] = wr; m_tag[s][vw] = tg;
    touch(s, vw);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int seed, cfgs [7];
    seed = $urandom(32'h5eed_0042);
    cfgs = '{0, 1, 2, 3, 5, 8, 9};
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0; m_order[s][w] = w;
      end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(req_ready == 1'b1, "R9", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R11", int'(resp_valid), 0);
    check(!wb_valid && !fill_valid, "R8", int'(wb_valid | fill_valid), 0);
    check(way_en == 8'h00, "R2", int'(way_en), 0);
    // R1: unrestricted partition.
    access(1, 0, 0, 100, 8);
    access(1, 0, 0, 100, 8);
    // R6 reset order then R4: fill set 1 with non-stack blocks, one dirty.
    for (int t = 1; t <= 8; t++) access(0, 0, 1, t, 2);
    access(0, 1, 1, 6, 2);                  // R12 write hit in way 5
    access(1, 0, 1, 6, 2);                  // R7 misplaced dirty block
    access(0, 1, 1, 40, 2);                 // R4 whole-set victim
    access(1, 1, 1, 41, 1);                 // R5 single stack way
    access(1, 0, 1, 42, 1);                 // R12 dirty victim written back
    access(1, 0, 2, 7, 0);                  // R2 zero read as one
    for (int i = 0; i < 1500; i++)
      access($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3),
             $urandom_range(1, 12), cfgs[$urandom_range(0, 6)]);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule